// File: doc/BRIEF.md
# Radix-4 Decimation-in-Time Butterfly for a 64-Point FFT

This block performs one radix-4 decimation-in-time butterfly of a 64-point complex FFT. On each cycle where `in_valid` is high it accepts four complex operands and a twiddle exponent. Lanes 1 to 3 are rotated by their twiddle factors. The four twiddled values are then combined by the radix-4 add/subtract network. Every result is halved, and the four complex results leave the block two clock cycles later, marked by `out_valid`.

The twiddle products need no general multipliers. Each input component drives a bank of fixed shift-and-add networks, one for each cosine magnitude that the 64-point transform needs. A first multiplexer picks the products for the fine angle. A second multiplexer applies the quarter-turn rotation, which is only a swap of real and imaginary parts and a sign change.

The surrounding processor supplies operands and exponents and writes the results back. Memory, addressing and sequencing are handled outside this block.

Top module: `r4_dit_butterfly`

## Requirements
- R1: `out_valid` rises exactly two rising clock edges after an edge that samples `in_valid` high. Each accepted operand set gives exactly one valid result cycle, and `out_valid` is never high without an accepted set.
- R2: While `rst_n` is low, `out_valid` and both output buses are zero. Reset acts asynchronously and is released in step with `clk`.
- R3: Operand lane m sits at bits [m*16 +: 16] of `in_re`/`in_im`. For m = 1..3 the lane is multiplied by W^p, where p = (m·`tw_exp`) mod 64 and W = exp(−j2π/64). With r = p[3:0], let c = round(2048·cos(πr/32)) and s = round(2048·cos(π(16−r)/32)). The twiddled real part is floor((xr·c + xi·s)/2048) and the twiddled imaginary part is floor((xi·c − xr·s)/2048). These products are formed by shift-and-add networks.
- R4: The quadrant q = p[5:4] then rotates the scaled twiddled value by (−j)^q. Each quarter step maps (a, b) to (b, −a), with no rounding.
- R5: With a0..a3 the twiddled lanes, result k equals the sum of a_m·(−j)^(m·k), computed without wrap-around for every input value including −32768. Result k sits at bits [k*18 +: 18] of `out_re`/`out_im` in two's complement.
- R6: Each result component is halved by an arithmetic right shift, so odd sums round toward minus infinity (−1 becomes −1, 1 becomes 0).
- R7: When no operand set is accepted, the output buses keep the last result, whatever values are present on the data and exponent inputs.
- R8: Lane 0 is never rotated. Its contribution does not depend on `tw_exp`.
- R9: A new operand set can be accepted on every cycle. Back-to-back sets give back-to-back results with no interference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set present this cycle |
| in_re | input | 64 | Real parts of the four operands, 16 bits per lane |
| in_im | input | 64 | Imaginary parts of the four operands, 16 bits per lane |
| tw_exp | input | 6 | Twiddle exponent e; lane m uses W^(m·e mod 64) |
| out_valid | output | 1 | Result set present this cycle |
| out_re | output | 72 | Real parts of the four halved results, 18 bits per lane |
| out_im | output | 72 | Imaginary parts of the four halved results, 18 bits per lane |

## Verification
Two activities can fall in the same cycle. One is the second stage capturing a finished result. The other is the first stage either loading a new operand set or holding while the inputs carry unrelated values. Long back-to-back bursts cause the first case, and single valid pulses separated by idle cycles with random data on every input cause the second. The bench compares every cycle's `out_valid` and all eight result components with a two-deep expectation pipeline built from its own floating-point-derived coefficients. A failed load or a failed hold therefore shows up in the exact cycle it occurs.

// File: rtl/r4b_pkg.sv
package r4b_pkg;

  // Fixed transform geometry: 64 points, coefficients in Q1.11.
  localparam int R4B_LOG2N     = 6;
  localparam int R4B_COEF_FRAC = 11;
  localparam int R4B_QTR_W     = R4B_LOG2N - 2;
  localparam int R4B_NQ        = (1 << R4B_QTR_W) + 1;   // cos(pi*q/32), q = 0..16
  localparam int R4B_CSD_DIG   = R4B_COEF_FRAC + 3;

  // Rounded magnitudes round(2^11 * cos(pi*q/32)).
  function automatic int coef_mag(input int q);
    case (q)
      0:  return 2048;
      1:  return 2038;
      2:  return 2009;
      3:  return 1960;
      4:  return 1892;
      5:  return 1806;
      6:  return 1703;
      7:  return 1583;
      8:  return 1448;
      9:  return 1299;
      10: return 1138;
      11: return 965;
      12: return 784;
      13: return 595;
      14: return 400;
      15: return 201;
      default: return 0;
    endcase
  endfunction

  // Canonical signed-digit recoding: positive digit positions.
  function automatic logic [15:0] csd_pos(input int k);
    logic [15:0] m;
    int v;
    m = '0;
    v = k;
    for (int i = 0; i < 16; i++) begin
      if ((v % 4) == 1) begin
        m[i] = 1'b1;
        v = v - 1;
      end else if ((v % 4) == 3) begin
        v = v + 1;
      end
      v = v / 2;
    end
    return m;
  endfunction

  // Canonical signed-digit recoding: negative digit positions.
  function automatic logic [15:0] csd_neg(input int k);
    logic [15:0] m;
    int v;
    m = '0;
    v = k;
    for (int i = 0; i < 16; i++) begin
      if ((v % 4) == 1) begin
        v = v - 1;
      end else if ((v % 4) == 3) begin
        m[i] = 1'b1;
        v = v + 1;
      end
      v = v / 2;
    end
    return m;
  endfunction

endpackage

// File: rtl/r4b_csd_mult.sv
module r4b_csd_mult
  import r4b_pkg::*;
#(
  parameter int COEF  = 0,
  parameter int IN_W  = 16,
  parameter int OUT_W = IN_W + R4B_COEF_FRAC + 2
) (
  input  logic signed [IN_W-1:0]  a,
  output logic signed [OUT_W-1:0] p
);

  localparam logic [15:0] POS = csd_pos(COEF);
  localparam logic [15:0] NEG = csd_neg(COEF);

  logic signed [OUT_W-1:0] a_ext;
  logic signed [OUT_W-1:0] acc;

  assign a_ext = OUT_W'(a);

  // Constant digit masks leave only the nonzero terms as adders.
  always_comb begin
    acc = '0;
    for (int i = 0; i < R4B_CSD_DIG; i++) begin
      if (POS[i]) begin
        acc = acc + (a_ext <<< i);
      end else if (NEG[i]) begin
        acc = acc - (a_ext <<< i);
      end
    end
    AST_CSD_PRODUCT: assert (acc == OUT_W'(a_ext * OUT_W'(COEF)))
      else $error("shift-add product differs from constant product"); // R3
  end

  assign p = acc;

endmodule

// File: rtl/r4b_twiddle_lane.sv
module r4b_twiddle_lane
  import r4b_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TW_W   = DATA_W + 1
) (
  input  logic signed [DATA_W-1:0]    x_re,
  input  logic signed [DATA_W-1:0]    x_im,
  input  logic        [R4B_LOG2N-1:0] pw,
  output logic signed [TW_W-1:0]      y_re,
  output logic signed [TW_W-1:0]      y_im
);

  localparam int PROD_W = DATA_W + R4B_COEF_FRAC + 2;
  localparam int ACC_W  = PROD_W + 1;

  logic signed [PROD_W-1:0] prod_re [R4B_NQ];
  logic signed [PROD_W-1:0] prod_im [R4B_NQ];

  // One fixed shift-add network per cosine magnitude and component.
  for (genvar q = 0; q < R4B_NQ; q++) begin : g_const
    r4b_csd_mult #(
      .COEF (coef_mag(q)),
      .IN_W (DATA_W),
      .OUT_W(PROD_W)
    ) u_mul_re (
      .a(x_re),
      .p(prod_re[q])
    );
    r4b_csd_mult #(
      .COEF (coef_mag(q)),
      .IN_W (DATA_W),
      .OUT_W(PROD_W)
    ) u_mul_im (
      .a(x_im),
      .p(prod_im[q])
    );
  end

  logic [R4B_QTR_W-1:0] fine;
  logic [1:0]           quad;
  logic [R4B_QTR_W:0]   idx_c;
  logic [R4B_QTR_W:0]   idx_s;
  logic signed [ACC_W-1:0] acc_re;
  logic signed [ACC_W-1:0] acc_im;
  logic signed [ACC_W-1:0] sc_re;
  logic signed [ACC_W-1:0] sc_im;
  logic signed [TW_W-1:0]  rs_re;
  logic signed [TW_W-1:0]  rs_im;

  always_comb begin
    fine  = pw[R4B_QTR_W-1:0];
    quad  = pw[R4B_LOG2N-1 -: 2];
    idx_c = {1'b0, fine};
    idx_s = (R4B_QTR_W+1)'(R4B_NQ - 1) - idx_c;

    // First selection level: fine-angle products.
    acc_re = ACC_W'(prod_re[idx_c]) + ACC_W'(prod_im[idx_s]);
    acc_im = ACC_W'(prod_im[idx_c]) - ACC_W'(prod_re[idx_s]);
    sc_re  = acc_re >>> R4B_COEF_FRAC;
    sc_im  = acc_im >>> R4B_COEF_FRAC;
    rs_re  = TW_W'(sc_re);
    rs_im  = TW_W'(sc_im);

    // Second selection level: quarter-turn rotation by (-j)^quad.
    case (quad)
      2'd0: begin y_re = rs_re;  y_im = rs_im;  end
      2'd1: begin y_re = rs_im;  y_im = -rs_re; end
      2'd2: begin y_re = -rs_re; y_im = -rs_im; end
      default: begin y_re = -rs_im; y_im = rs_re; end
    endcase

    AST_SCALE_FITS: assert (sc_re == ACC_W'(rs_re) && sc_im == ACC_W'(rs_im))
      else $error("scaled twiddle product lost its upper bits"); // R3
    if (pw == '0) begin
      AST_UNIT_TWIDDLE: assert (y_re == TW_W'(x_re) && y_im == TW_W'(x_im))
        else $error("zero exponent changed the operand"); // R4
    end
  end

endmodule

// File: rtl/r4b_bfly_core.sv
module r4b_bfly_core #(
  parameter int TW_W  = 17,
  parameter int OUT_W = TW_W + 1
) (
  input  logic [4*TW_W-1:0]  a_re,
  input  logic [4*TW_W-1:0]  a_im,
  output logic [4*OUT_W-1:0] z_re,
  output logic [4*OUT_W-1:0] z_im
);

  localparam int SUM_W = TW_W + 2;

  logic signed [SUM_W-1:0] er [4];
  logic signed [SUM_W-1:0] ei [4];
  logic signed [SUM_W-1:0] xr [4];
  logic signed [SUM_W-1:0] xi [4];
  logic signed [SUM_W-1:0] hr;
  logic signed [SUM_W-1:0] hi;
  logic signed [SUM_W-1:0] t0r, t1r, t2r, t3r;
  logic signed [SUM_W-1:0] t0i, t1i, t2i, t3i;

  always_comb begin
    for (int m = 0; m < 4; m++) begin
      er[m] = SUM_W'($signed(a_re[m*TW_W +: TW_W]));
      ei[m] = SUM_W'($signed(a_im[m*TW_W +: TW_W]));
    end

    // Two radix-2 layers; the -j factor is a swap with one negation.
    t0r = er[0] + er[2];  t0i = ei[0] + ei[2];
    t1r = er[0] - er[2];  t1i = ei[0] - ei[2];
    t2r = er[1] + er[3];  t2i = ei[1] + ei[3];
    t3r = er[1] - er[3];  t3i = ei[1] - ei[3];

    xr[0] = t0r + t2r;  xi[0] = t0i + t2i;
    xr[1] = t1r + t3i;  xi[1] = t1i - t3r;
    xr[2] = t0r - t2r;  xi[2] = t0i - t2i;
    xr[3] = t1r - t3i;  xi[3] = t1i + t3r;

    z_re = '0;
    z_im = '0;
    hr   = '0;
    hi   = '0;
    for (int k = 0; k < 4; k++) begin
      hr = xr[k] >>> 1;
      hi = xi[k] >>> 1;
      z_re[k*OUT_W +: OUT_W] = OUT_W'(hr);
      z_im[k*OUT_W +: OUT_W] = OUT_W'(hi);
      AST_HALF_FITS: assert (hr == SUM_W'($signed(OUT_W'(hr))) && hi == SUM_W'($signed(OUT_W'(hi))))
        else $error("halved result exceeds output width"); // R6
    end
  end

endmodule

// File: rtl/r4_dit_butterfly.sv
module r4_dit_butterfly
  import r4b_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int LANES = 4,
  localparam int TW_W  = DATA_W + 1,
  localparam int OUT_W = DATA_W + 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [LANES*DATA_W-1:0]    in_re,
  input  logic [LANES*DATA_W-1:0]    in_im,
  input  logic [R4B_LOG2N-1:0]       tw_exp,
  output logic                       out_valid,
  output logic [LANES*OUT_W-1:0]     out_re,
  output logic [LANES*OUT_W-1:0]     out_im
);

  logic [LANES*TW_W-1:0] tw_re;
  logic [LANES*TW_W-1:0] tw_im;

  // Lane 0 always carries W^0 and bypasses the constant networks.
  assign tw_re[0 +: TW_W] = TW_W'($signed(in_re[0 +: DATA_W]));
  assign tw_im[0 +: TW_W] = TW_W'($signed(in_im[0 +: DATA_W]));

  for (genvar m = 1; m < LANES; m++) begin : g_lane
    logic [R4B_LOG2N-1:0] pw;
    assign pw = R4B_LOG2N'(m * int'(tw_exp));
    r4b_twiddle_lane #(
      .DATA_W(DATA_W),
      .TW_W  (TW_W)
    ) u_lane (
      .x_re($signed(in_re[m*DATA_W +: DATA_W])),
      .x_im($signed(in_im[m*DATA_W +: DATA_W])),
      .pw  (pw),
      .y_re(tw_re[m*TW_W +: TW_W]),
      .y_im(tw_im[m*TW_W +: TW_W])
    );
  end

  // Stage registers and their next values.
  logic                   s1_valid_q, s1_valid_d, s1_load;
  logic [LANES*TW_W-1:0]  s1_re_q, s1_re_d;
  logic [LANES*TW_W-1:0]  s1_im_q, s1_im_d;
  logic                   s2_valid_q, s2_valid_d, s2_load;
  logic [LANES*OUT_W-1:0] s2_re_q, s2_re_d;
  logic [LANES*OUT_W-1:0] s2_im_q, s2_im_d;
  logic [LANES*OUT_W-1:0] bf_re, bf_im;

  r4b_bfly_core #(
    .TW_W (TW_W),
    .OUT_W(OUT_W)
  ) u_core (
    .a_re(s1_re_q),
    .a_im(s1_im_q),
    .z_re(bf_re),
    .z_im(bf_im)
  );

  always_comb begin
    s1_valid_d = in_valid;
    s1_load    = in_valid;
    s1_re_d    = tw_re;
    s1_im_d    = tw_im;
    s2_valid_d = s1_valid_q;
    s2_load    = s1_valid_q;
    s2_re_d    = bf_re;
    s2_im_d    = bf_im;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_re_q    <= '0;
      s1_im_q    <= '0;
      s2_valid_q <= 1'b0;
      s2_re_q    <= '0;
      s2_im_q    <= '0;
    end else begin
      s1_valid_q <= s1_valid_d;
      if (s1_load) begin
        s1_re_q <= s1_re_d;
        s1_im_q <= s1_im_d;
      end
      s2_valid_q <= s2_valid_d;
      if (s2_load) begin
        s2_re_q <= s2_re_d;
        s2_im_q <= s2_im_d;
      end
    end
  end

  assign out_valid = s2_valid_q;
  assign out_re    = s2_re_q;
  assign out_im    = s2_im_q;

  AST_S1_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid_q) else $error("accepted set missing in stage 1"); // R1
  AST_OUT_FOLLOWS_S1: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid_q |=> out_valid) else $error("stage 1 set did not reach output"); // R1
  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid_q |=> !out_valid) else $error("output valid without a set"); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid_q |=> ($stable(out_re) && $stable(out_im))) else $error("outputs moved while idle"); // R7

endmodule

// File: tb/test_r4_dit_butterfly.sv
`timescale 1ns/1ps
module test_r4_dit_butterfly;

  localparam int DW = 16;
  localparam int OW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid;
  logic [4*DW-1:0] in_re, in_im;
  logic [5:0]    tw_exp;
  logic          out_valid;
  logic [4*OW-1:0] out_re, out_im;

  always #2 clk = ~clk;

  r4_dit_butterfly #(.DATA_W(DW)) i_r4_dit_butterfly (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .tw_exp(tw_exp), .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  int st_re[4], st_im[4];
  int st_e;
  int md_re[4], md_im[4];
  int ex_re[2][4], ex_im[2][4];
  bit ex_v[2];
  string ex_tag[2];

  function automatic int coef(int q);
    return $rtoi(2048.0 * $cos(3.14159265358979 * q / 32.0) + 0.5);
  endfunction

  function automatic int rnd16();
    return int'($signed(16'($urandom)));
  endfunction

  // Reference: twiddle, quarter rotation, radix-4 sums, floor halving.
  function automatic void model(int e);
    int ar[4], ai[4];
    int p, r, qd, c, s, tr, ti, tmp;
    ar[0] = st_re[0];
    ai[0] = st_im[0];
    for (int m = 1; m < 4; m++) begin
      p  = (m * e) % 64;
      r  = p % 16;
      qd = p / 16;
      c  = coef(r);
      s  = coef(16 - r);
      tr = (st_re[m] * c + st_im[m] * s) >>> 11;
      ti = (st_im[m] * c - st_re[m] * s) >>> 11;
      for (int k = 0; k < qd; k++) begin
        tmp = tr; tr = ti; ti = -tmp;
      end
      ar[m] = tr;
      ai[m] = ti;
    end
    for (int k = 0; k < 4; k++) begin
      int sr, si;
      sr = 0; si = 0;
      for (int m = 0; m < 4; m++) begin
        case ((m * k) % 4)
          0: begin sr += ar[m]; si += ai[m]; end
          1: begin sr += ai[m]; si -= ar[m]; end
          2: begin sr -= ar[m]; si -= ai[m]; end
          default: begin sr -= ai[m]; si += ar[m]; end
        endcase
      end
      md_re[k] = sr >>> 1;
      md_im[k] = si >>> 1;
    end
  endfunction

  task automatic compare();
    string msg;
    bit bad;
    bad = 0;
    n_cmp++;
    if (out_valid !== ex_v[1]) begin
      bad = 1;
      msg = $sformatf("out_valid actual %0d expected %0d", out_valid, ex_v[1]);
    end else begin
      for (int k = 0; k < 4; k++) begin
        int gr, gi;
        gr = int'($signed(out_re[k*OW +: OW]));
        gi = int'($signed(out_im[k*OW +: OW]));
        if (!bad && gr != ex_re[1][k]) begin
          bad = 1;
          msg = $sformatf("lane %0d re actual %0d expected %0d", k, gr, ex_re[1][k]);
        end
        if (!bad && gi != ex_im[1][k]) begin
          bad = 1;
          msg = $sformatf("lane %0d im actual %0d expected %0d", k, gi, ex_im[1][k]);
        end
      end
    end
    if (bad) begin
      n_bad++;
      $display("FAIL %s: %s", ex_tag[1], msg);
    end
  endtask

  task automatic cycle(bit v, string tag);
    @(negedge clk);
    compare();
    ex_v[1] = ex_v[0];
    ex_tag[1] = ex_tag[0];
    for (int k = 0; k < 4; k++) begin
      ex_re[1][k] = ex_re[0][k];
      ex_im[1][k] = ex_im[0][k];
    end
    if (v) begin
      model(st_e);
      for (int k = 0; k < 4; k++) begin
        ex_re[0][k] = md_re[k];
        ex_im[0][k] = md_im[k];
      end
    end
    ex_v[0] = v;
    ex_tag[0] = tag;
    in_valid = v;
    for (int k = 0; k < 4; k++) begin
      in_re[k*DW +: DW] = st_re[k][15:0];
      in_im[k*DW +: DW] = st_im[k][15:0];
    end
    tw_exp = st_e[5:0];
  endtask

  task automatic randomize_set();
    for (int k = 0; k < 4; k++) begin
      st_re[k] = rnd16();
      st_im[k] = rnd16();
    end
    st_e = int'($urandom % 64);
  endtask

  task automatic fill(int vr, int vi, int e);
    for (int k = 0; k < 4; k++) begin
      st_re[k] = vr;
      st_im[k] = vi;
    end
    st_e = e;
  endtask

  task automatic check_reset_state(string tag);
    n_cmp++;
    if (out_valid !== 1'b0 || out_re !== '0 || out_im !== '0) begin
      n_bad++;
      $display("FAIL %s: reset state actual valid=%0d re=%h im=%h expected all zero",
               tag, out_valid, out_re, out_im);
    end
  endtask

  task automatic clear_model();
    for (int j = 0; j < 2; j++) begin
      ex_v[j] = 0;
      ex_tag[j] = "R2";
      for (int k = 0; k < 4; k++) begin
        ex_re[j][k] = 0;
        ex_im[j][k] = 0;
      end
    end
  endtask

  initial begin
    in_valid = 0; in_re = '0; in_im = '0; tw_exp = '0;
    fill(0, 0, 0);
    clear_model();
    void'($urandom(7321));
    repeat (3) @(negedge clk);
    check_reset_state("R2");
    rst_n = 1'b1;

    // R1: isolated pulse, then idle cycles.
    randomize_set(); st_e = 5;
    cycle(1, "R1");
    for (int i = 0; i < 4; i++) begin randomize_set(); cycle(0, "R1"); end

    // R5: extreme operands with the unit twiddle.
    fill(32767, 32767, 0);   cycle(1, "R5");
    fill(-32768, -32768, 0); cycle(1, "R5");
    fill(32767, -32768, 0);  cycle(1, "R5");
    // R6: odd sums rounding toward minus infinity.
    fill(0, 0, 0); st_re[0] = 1;  st_im[0] = -1; cycle(1, "R6");
    fill(0, 0, 0); st_re[0] = -3; st_im[0] = 3;  st_re[2] = 0; cycle(1, "R6");
    fill(0, 0, 0); st_re[1] = -1; st_im[3] = 1;  cycle(1, "R6");

    // R5: full-scale operands across every exponent.
    for (int e = 0; e < 64; e++) begin fill(-32768, -32768, e); cycle(1, "R5"); end
    for (int e = 0; e < 64; e++) begin fill(32767, -32768, e);  cycle(1, "R5"); end

    // R3 / R4: random data over the whole exponent range.
    for (int rep = 0; rep < 4; rep++) begin
      for (int e = 0; e < 64; e++) begin
        randomize_set(); st_e = e;
        cycle(1, (e >= 16) ? "R4" : "R3");
      end
    end

    // R8: only lane 0 driven, exponent varied.
    for (int i = 0; i < 30; i++) begin
      randomize_set();
      for (int k = 1; k < 4; k++) begin st_re[k] = 0; st_im[k] = 0; end
      cycle(1, "R8");
    end

    // R7: valid pulse followed by idle cycles carrying noise.
    for (int i = 0; i < 25; i++) begin
      randomize_set(); cycle(1, "R7");
      for (int j = 0; j < 3; j++) begin randomize_set(); cycle(0, "R7"); end
    end

    // R9: long back-to-back burst with random gaps.
    for (int i = 0; i < 1200; i++) begin
      randomize_set();
      cycle(($urandom % 8) != 0, "R9");
    end

    // R2: reset in mid-run with a result on the outputs.
    randomize_set(); cycle(1, "R2");
    randomize_set(); cycle(1, "R2");
    cycle(0, "R2");
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 0;
    #1;
    check_reset_state("R2");
    clear_model();
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin randomize_set(); cycle(0, "R2"); end
    randomize_set(); cycle(1, "R1");
    for (int i = 0; i < 3; i++) cycle(0, "R1");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1: watchdog actual run still busy expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule